// File: doc/BRIEF.md
# Prioritized Microtask Switcher

Eight hardware microtasks share a single microsequencer, and this block chooses which of them owns it. Six of the tasks serve I/O devices and have fixed priorities, from highest to lowest: video (ID 0), network (ID 1), disk (ID 2), periodic timer (ID 3), mouse (ID 4) and keyboard (ID 5). Tasks 6 and 7 are computation threads. They rank below every I/O task and fill every cycle in which no I/O task needs service.

Each task has a wakeup line and its own saved micro-PC. A task can only be replaced when the running task marks a switch point, for example the end of an instruction or the cycle after it accesses a shift register. At that point the block stores the running task's successor micro-PC in that task's slot. It then hands the sequencer to the winning task at the micro-PC that task last saved, so each task resumes where it stopped. Between switch points the running task simply steps along the successor micro-PCs that the sequencer returns. The outputs are the current task ID and the micro-PC to fetch.

Top module: `utask_switch`

## Requirements
- R1: After reset, task_o is 6, upc_o is 0, every saved micro-PC is 0 and no request is pending.
- R2: At a switch point, the lowest-numbered requesting I/O task (IDs 0 to 5) wins, so video beats network, network beats disk, and so on down to keyboard.
- R3: Any requesting I/O task wins over both computation threads.
- R4: When no I/O task requests, task 6 runs. Task 7 runs only when it requests and task 6 does not.
- R5: task_o changes only in the cycle after boundary_i was high.
- R6: In a cycle without a switch point, upc_o in the next cycle equals the next_upc_i value presented in this cycle.
- R7: A wakeup bit (bit k for task k) that is seen while boundary_i is low stays pending until the task is selected at a switch point. Selection clears it.
- R8: At a switch point, next_upc_i is saved for the running task. A task that is switched in starts at the micro-PC it saved most recently, or 0 if it has never saved one.
- R9: If the running task wins again at a switch point, upc_o continues at next_upc_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wake_i | input | 8 | Wakeup request, bit k for task k |
| boundary_i | input | 1 | Running task is at a switch point this cycle |
| next_upc_i | input | UPC_W | Successor micro-PC of the running task |
| task_o | output | 3 | ID of the running task |
| upc_o | output | UPC_W | Micro-PC to fetch for the running task |

## Verification
The assertions assume that boundary_i, wake_i and next_upc_i are known, two-state values in every cycle after reset, and that boundary_i is sampled at the clock edge that ends the running task's cycle. The priority checks look only at wakeup lines that are present together with a switch point. Bits pending from earlier cycles can only add higher-priority winners, so the properties are written to hold whatever the pending state is. The stimulus drives every input on the falling edge with defined values. It sweeps all 256 wakeup patterns at switch points and then mixes long runs without switch points into a pseudo-random phase.

// File: rtl/utsw_pkg.sv
package utsw_pkg;
  localparam int unsigned NTASK  = 8;
  localparam int unsigned TID_W  = $clog2(NTASK);
  localparam int unsigned N_IO   = 6;
  localparam logic [TID_W-1:0] IDLE_TID = TID_W'(N_IO);
endpackage

// File: rtl/utsw_req_latch.sv
module utsw_req_latch
  import utsw_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NTASK-1:0] wake_i,
  input  logic             take_i,
  input  logic [TID_W-1:0] take_id_i,
  output logic [NTASK-1:0] req_o
);
  logic [NTASK-1:0] pend_q;

  assign req_o = pend_q | wake_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else begin
      for (int i = 0; i < NTASK; i++)
        pend_q[i] <= req_o[i] & ~(take_i && take_id_i == TID_W'(i));
    end
  end
endmodule

// File: rtl/utsw_prio_pick.sv
module utsw_prio_pick
  import utsw_pkg::*;
(
  input  logic [NTASK-1:0] req_i,
  output logic [TID_W-1:0] win_o
);
  // lowest index wins; no request falls back to the first computation thread
  always_comb begin
    win_o = IDLE_TID;
    for (int i = NTASK - 1; i >= 0; i--)
      if (req_i[i]) win_o = TID_W'(i);
  end
endmodule

// File: rtl/utsw_upc_bank.sv
module utsw_upc_bank
  import utsw_pkg::*;
#(
  parameter int unsigned UPC_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [TID_W-1:0] wr_id_i,
  input  logic [UPC_W-1:0] wr_upc_i,
  input  logic [TID_W-1:0] rd_id_i,
  output logic [UPC_W-1:0] rd_upc_o
);
  logic [UPC_W-1:0] slot_q [NTASK];

  for (genvar g = 0; g < NTASK; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) slot_q[g] <= '0;
      else if (wr_en_i && wr_id_i == TID_W'(g)) slot_q[g] <= wr_upc_i;
    end
  end

  assign rd_upc_o = slot_q[rd_id_i];
endmodule

// File: rtl/utask_switch.sv
module utask_switch
  import utsw_pkg::*;
#(
  parameter int unsigned UPC_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       wake_i,
  input  logic             boundary_i,
  input  logic [UPC_W-1:0] next_upc_i,
  output logic [2:0]       task_o,
  output logic [UPC_W-1:0] upc_o
);
  logic [NTASK-1:0] req;
  logic [TID_W-1:0] win, cur_q;
  logic [UPC_W-1:0] saved_upc, upc_q;

  utsw_req_latch u_req (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wake_i   (wake_i),
    .take_i   (boundary_i),
    .take_id_i(win),
    .req_o    (req)
  );

  utsw_prio_pick u_pick (
    .req_i(req),
    .win_o(win)
  );

  utsw_upc_bank #(.UPC_W(UPC_W)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (boundary_i),
    .wr_id_i (cur_q),
    .wr_upc_i(next_upc_i),
    .rd_id_i (win),
    .rd_upc_o(saved_upc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= IDLE_TID;
      upc_q <= '0;
    end else if (boundary_i) begin
      cur_q <= win;
      // bank slot of the running task is stale in this cycle
      upc_q <= (win == cur_q) ? next_upc_i : saved_upc;
    end else begin
      upc_q <= next_upc_i;
    end
  end

  assign task_o = cur_q;
  assign upc_o  = upc_q;
endmodule

// File: rtl/utask_switch_chk.sv
module utask_switch_chk #(
  parameter int unsigned UPC_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [7:0]       wake_i,
  input logic             boundary_i,
  input logic [UPC_W-1:0] next_upc_i,
  input logic [2:0]       task_o,
  input logic [UPC_W-1:0] upc_o
);
  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else armed_q <= 1'b1;
  end

  // R5
  task_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    !$past(boundary_i) |-> $stable(task_o));

  // R6
  upc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    !$past(boundary_i) |-> upc_o == $past(next_upc_i));

  // R2
  video_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boundary_i && wake_i[0] |=> task_o == 3'd0);

  // R3
  io_over_comp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boundary_i && (|wake_i[5:0]) |=> task_o < 3'd6);

  // R4
  comp6_over_7_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boundary_i && wake_i[6] |=> task_o != 3'd7);

  // R9
  same_task_cont_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boundary_i && wake_i[0] && task_o == 3'd0 |=> upc_o == $past(next_upc_i));
endmodule

bind utask_switch utask_switch_chk #(.UPC_W(UPC_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wake_i    (wake_i),
  .boundary_i(boundary_i),
  .next_upc_i(next_upc_i),
  .task_o    (task_o),
  .upc_o     (upc_o)
);

// File: tb/sim_utask_switch.sv
module sim_utask_switch;
  localparam int UW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    wake = '0;
  logic          bnd = 1'b0;
  logic [UW-1:0] nupc = '0;
  logic [2:0]    task_id;
  logic [UW-1:0] upc;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [7:0]    m_pend;
  logic [UW-1:0] m_saved [8];
  int            m_cur;
  logic [UW-1:0] m_upc;

  always #2.5 clk = ~clk;

  utask_switch #(.UPC_W(UW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wake_i(wake), .boundary_i(bnd),
    .next_upc_i(nupc), .task_o(task_id), .upc_o(upc)
  );

  task automatic compare(input string req);
    checks++;
    if (task_id !== 3'(m_cur) || upc !== m_upc) begin
      errors++;
      $display("FAIL %s: task=%0d upc=%0d expected task=%0d upc=%0d",
               req, task_id, upc, m_cur, m_upc);
    end
  endtask

  // called at a falling edge; checks at the following falling edge
  task automatic cyc(input logic [7:0] w, input logic b, input logic [UW-1:0] n,
                     input string req);
    logic [7:0] eff;
    int win;
    wake = w; bnd = b; nupc = n;
    eff = m_pend | w;
    if (b) begin
      win = 6;
      for (int i = 7; i >= 0; i--) if (eff[i]) win = i;
      m_upc = (win == m_cur) ? n : m_saved[win];
      m_saved[m_cur] = n;
      eff[win] = 1'b0;
      m_cur = win;
    end else begin
      m_upc = n;
    end
    m_pend = eff;
    @(negedge clk);
    compare(req);
  endtask

  initial begin
    #500us;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    m_pend = '0; m_cur = 6; m_upc = '0;
    for (int i = 0; i < 8; i++) m_saved[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    cyc(8'h00, 0, 10'd5,  "R6");
    cyc(8'h20, 0, 10'd9,  "R5");
    cyc(8'h00, 1, 10'd12, "R7");
    cyc(8'h30, 1, 10'd3,  "R2");
    cyc(8'h00, 1, 10'd7,  "R8");
    cyc(8'h00, 1, 10'd20, "R8");
    cyc(8'h80, 1, 10'd13, "R4");
    cyc(8'hC0, 1, 10'd30, "R4");
    cyc(8'h01, 1, 10'd40, "R3");
    cyc(8'h01, 1, 10'd41, "R9");
    cyc(8'h00, 1, 10'd50, "R4");
    cyc(8'h00, 0, 10'd51, "R6");

    for (int p = 0; p < 256; p++) begin
      cyc(8'(p), 1, 10'(p + 100), "R2/R3/R4");
      cyc(8'h00, 0, 10'(p + 400), "R5/R6");
    end

    lfsr = 16'hACE1;
    for (int k = 0; k < 2000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc((lfsr[3:0] == 4'd0) ? lfsr[15:8] : 8'h00, lfsr[5] & lfsr[6],
          lfsr[9:0], "R7/R8/R9");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule